// File: doc/BRIEF.md
# Trap Enable and Privilege Stack

This block decides, cycle by cycle, whether a hart with two privilege levels (machine and user) should take an interrupt now, and which source it should take. It also keeps the small hardware stack of status state that trap entry saves and trap return restores: the live interrupt enable, the saved enable, the saved privilege level and the modify-privilege bit. The interrupt decision is combinational on the pending and enable inputs and the registered state. The status fields change only on a clock edge.

The privilege level is the state of a two-state machine, `ST` encoded as the privilege code itself. `PRIV_MACH` (code 2'b11) is the reset state. `PRIV_USER` (code 2'b00) is the other state. The transitions are as follows:

- TRAP_ENTER moves from either state to `PRIV_MACH`.
- TRAP_RETURN, taken in `PRIV_MACH` only, moves to the state held in the saved-privilege field.
- STATUS_WRITE loads the status fields and keeps the current state.

The global enable depends on the privilege level. In user mode, machine-level interrupts are always globally enabled. In machine mode, they are globally enabled only when the enable bit is set. The surrounding core supplies the strobes, acts on the take request, and computes the vector address.

Top module: `trap_priv_ctrl`

## Requirements
- R1: After reset, the block is in the following state:
  - the privilege output is 2'b11 (machine);
  - the enable, saved-enable and modify-privilege bits are 0;
  - the saved privilege is 2'b00 (user);
  - no interrupt is requested.
- R2: In machine mode (privilege 2'b11), no interrupt is requested while the enable bit is 0. When the enable bit is 1, an interrupt is requested in the same cycle that a source is pending and enabled.
- R3: In user mode (privilege 2'b00), an interrupt is requested whenever a source is pending and enabled, whatever the enable bit holds.
- R4: Only bit 3 (software), bit 7 (timer) and bit 11 (external) of the pending and per-source enable vectors are sources. A source counts only when its pending bit and its enable bit are both 1. All other bit positions are ignored.
- R5: When several sources qualify, external wins over software, and software wins over timer. The cause output is formed as follows:
  - its top bit is 1;
  - its low bits hold the winning bit index (11, 3 or 7);
  - all other bits are 0.
  The cause output is all zeros when no interrupt is requested.
- R6: On trap entry, the following happens at the next clock edge:
  - the saved enable takes the current enable;
  - the enable clears;
  - the saved privilege takes the current privilege;
  - the privilege becomes machine;
  - the modify-privilege bit is unchanged.
- R7: On trap return in machine mode, the following happens at the next clock edge:
  - the enable takes the saved enable;
  - the saved enable becomes 1;
  - the privilege takes the saved privilege;
  - the saved privilege becomes user;
  - the modify-privilege bit clears if the return lands in user mode, and is kept otherwise.
  In user mode, a trap return has no effect.
- R8: When strobes coincide, trap entry takes priority over trap return and over a status write in the same cycle. Trap return takes priority over a status write.
- R9: A status write loads the enable, saved-enable, saved-privilege and modify-privilege fields at the next clock edge. A written privilege value of 2'b11 is stored as machine, and any other value is stored as user (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend_i | input | IRQ_W | Pending interrupt lines by bit index |
| irq_en_i | input | IRQ_W | Per-source interrupt enables |
| trap_enter_i | input | 1 | Trap entry strobe |
| trap_return_i | input | 1 | Trap return strobe |
| stat_wr_i | input | 1 | Status field write strobe |
| stat_ie_i | input | 1 | Write value for the enable bit |
| stat_pie_i | input | 1 | Write value for the saved enable |
| stat_pp_i | input | 2 | Write value for the saved privilege |
| stat_mprv_i | input | 1 | Write value for the modify-privilege bit |
| priv_o | output | 2 | Current privilege: 2'b11 machine, 2'b00 user |
| ie_o | output | 1 | Machine interrupt enable |
| pie_o | output | 1 | Saved interrupt enable |
| pp_o | output | 2 | Saved privilege |
| mprv_o | output | 1 | Modify-privilege bit |
| irq_take_o | output | 1 | Take-interrupt request |
| irq_cause_o | output | CAUSE_W | Cause of the chosen interrupt |

## Verification
The assertions assume that the strobes are sampled only on clock edges after reset. They also assume that a trap return issued in user mode is meaningless and is simply ignored, so the stack-pop properties are conditioned on machine mode and on the absence of a coincident trap entry.

The stimulus drives every input at the falling edge and holds it for a full cycle. Its strobe combinations are limited to the cases that R8 orders, and the sources are restricted to the fixed bit positions of R4. Non-source bits are raised only to show that they are ignored.

// File: rtl/trap_priv_pkg.sv
package trap_priv_pkg;
    typedef enum logic [1:0] {
        PRIV_USER = 2'b00,
        PRIV_MACH = 2'b11
    } priv_e;

    // Source bit positions decoded by the interrupt controller.
    localparam int SRC_SW  = 3;
    localparam int SRC_TIM = 7;
    localparam int SRC_EXT = 11;
endpackage

// File: rtl/trap_priv_fsm.sv
module trap_priv_fsm
    import trap_priv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trap_enter_i,
    input  logic       trap_return_i,
    input  logic       stat_wr_i,
    input  logic       stat_ie_i,
    input  logic       stat_pie_i,
    input  logic [1:0] stat_pp_i,
    input  logic       stat_mprv_i,
    output logic [1:0] priv_o,
    output logic       ie_o,
    output logic       pie_o,
    output logic [1:0] pp_o,
    output logic       mprv_o,
    output logic       glb_en_o
);
    priv_e state_q, state_d;
    priv_e pp_q, pp_d, pp_wr;
    logic  ie_q, ie_d, pie_q, pie_d, mprv_q, mprv_d;

    assign pp_wr = (stat_pp_i == 2'b11) ? PRIV_MACH : PRIV_USER;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PRIV_MACH;
            ie_q    <= 1'b0;
            pie_q   <= 1'b0;
            pp_q    <= PRIV_USER;
            mprv_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ie_q    <= ie_d;
            pie_q   <= pie_d;
            pp_q    <= pp_d;
            mprv_q  <= mprv_d;
        end
    end

    // Next state and stack update
    always_comb begin
        state_d = state_q;
        ie_d    = ie_q;
        pie_d   = pie_q;
        pp_d    = pp_q;
        mprv_d  = mprv_q;
        unique case (state_q)
            PRIV_MACH: begin
                if (trap_enter_i) begin
                    pie_d   = ie_q;
                    ie_d    = 1'b0;
                    pp_d    = PRIV_MACH;
                    state_d = PRIV_MACH;
                end else if (trap_return_i) begin
                    ie_d    = pie_q;
                    pie_d   = 1'b1;
                    state_d = pp_q;
                    pp_d    = PRIV_USER;
                    if (pp_q == PRIV_USER) mprv_d = 1'b0;
                end else if (stat_wr_i) begin
                    ie_d   = stat_ie_i;
                    pie_d  = stat_pie_i;
                    pp_d   = pp_wr;
                    mprv_d = stat_mprv_i;
                end
            end
            PRIV_USER: begin
                if (trap_enter_i) begin
                    pie_d   = ie_q;
                    ie_d    = 1'b0;
                    pp_d    = PRIV_USER;
                    state_d = PRIV_MACH;
                end else if (stat_wr_i) begin
                    ie_d   = stat_ie_i;
                    pie_d  = stat_pie_i;
                    pp_d   = pp_wr;
                    mprv_d = stat_mprv_i;
                end
            end
            default: state_d = PRIV_MACH;
        endcase
    end

    // Outputs
    always_comb begin
        priv_o   = state_q;
        ie_o     = ie_q;
        pie_o    = pie_q;
        pp_o     = pp_q;
        mprv_o   = mprv_q;
        glb_en_o = (state_q == PRIV_USER) || ie_q;
    end
endmodule

// File: rtl/trap_irq_arb.sv
module trap_irq_arb
    import trap_priv_pkg::*;
#(
    parameter int IRQ_W   = 16,
    parameter int CAUSE_W = 32
) (
    input  logic [IRQ_W-1:0]   pend_i,
    input  logic [IRQ_W-1:0]   en_i,
    input  logic               glb_en_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int IDX_W  = $clog2(IRQ_W);
    localparam int NPRIO  = 3;
    localparam int PRIO [NPRIO] = '{SRC_EXT, SRC_SW, SRC_TIM};

    logic [IRQ_W-1:0] ready;
    logic [IDX_W-1:0] idx;

    assign ready = pend_i & en_i;

    always_comb begin
        take_o = 1'b0;
        idx    = '0;
        for (int k = NPRIO - 1; k >= 0; k--) begin
            if (glb_en_i && ready[PRIO[k]]) begin
                take_o = 1'b1;
                idx    = IDX_W'(PRIO[k]);
            end
        end
        cause_o = '0;
        if (take_o) begin
            cause_o[CAUSE_W-1]  = 1'b1;
            cause_o[IDX_W-1:0]  = idx;
        end
    end
endmodule

// File: rtl/trap_priv_ctrl.sv
module trap_priv_ctrl
    import trap_priv_pkg::*;
#(
    parameter int IRQ_W   = 16,
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IRQ_W-1:0]   irq_pend_i,
    input  logic [IRQ_W-1:0]   irq_en_i,
    input  logic               trap_enter_i,
    input  logic               trap_return_i,
    input  logic               stat_wr_i,
    input  logic               stat_ie_i,
    input  logic               stat_pie_i,
    input  logic [1:0]         stat_pp_i,
    input  logic               stat_mprv_i,
    output logic [1:0]         priv_o,
    output logic               ie_o,
    output logic               pie_o,
    output logic [1:0]         pp_o,
    output logic               mprv_o,
    output logic               irq_take_o,
    output logic [CAUSE_W-1:0] irq_cause_o
);
    logic glb_en;

    trap_priv_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_enter_i (trap_enter_i),
        .trap_return_i(trap_return_i),
        .stat_wr_i    (stat_wr_i),
        .stat_ie_i    (stat_ie_i),
        .stat_pie_i   (stat_pie_i),
        .stat_pp_i    (stat_pp_i),
        .stat_mprv_i  (stat_mprv_i),
        .priv_o       (priv_o),
        .ie_o         (ie_o),
        .pie_o        (pie_o),
        .pp_o         (pp_o),
        .mprv_o       (mprv_o),
        .glb_en_o     (glb_en)
    );

    trap_irq_arb #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_arb (
        .pend_i  (irq_pend_i),
        .en_i    (irq_en_i),
        .glb_en_i(glb_en),
        .take_o  (irq_take_o),
        .cause_o (irq_cause_o)
    );
endmodule

// File: rtl/trap_priv_ctrl_chk.sv
module trap_priv_ctrl_chk
    import trap_priv_pkg::*;
#(
    parameter int IRQ_W   = 16,
    parameter int CAUSE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [IRQ_W-1:0]   irq_pend_i,
    input logic [IRQ_W-1:0]   irq_en_i,
    input logic               trap_enter_i,
    input logic               trap_return_i,
    input logic [1:0]         priv_o,
    input logic               ie_o,
    input logic               pie_o,
    input logic [1:0]         pp_o,
    input logic               mprv_o,
    input logic               irq_take_o,
    input logic [CAUSE_W-1:0] irq_cause_o
);
    localparam logic [IRQ_W-1:0] SRC_MASK =
        (IRQ_W'(1) << SRC_SW) | (IRQ_W'(1) << SRC_TIM) | (IRQ_W'(1) << SRC_EXT);
    localparam logic [CAUSE_W-1:0] EXT_CAUSE =
        (CAUSE_W'(1) << (CAUSE_W - 1)) | CAUSE_W'(SRC_EXT);

    // R2
    machine_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_o == 2'b11 && !ie_o) |-> !irq_take_o);

    // R3
    user_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_o == 2'b00 && |(irq_pend_i & irq_en_i & SRC_MASK)) |-> irq_take_o);

    // R5
    ext_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take_o && irq_pend_i[SRC_EXT] && irq_en_i[SRC_EXT]) |-> irq_cause_o == EXT_CAUSE);

    // R6
    trap_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter_i |=> (priv_o == 2'b11 && !ie_o && pie_o == $past(ie_o)
                          && pp_o == $past(priv_o) && mprv_o == $past(mprv_o)));

    // R7
    trap_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_return_i && !trap_enter_i && priv_o == 2'b11) |=>
            (ie_o == $past(pie_o) && pie_o && priv_o == $past(pp_o) && pp_o == 2'b00));

    // R7
    mprv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_return_i && !trap_enter_i && priv_o == 2'b11 && pp_o == 2'b00) |=> !mprv_o);
endmodule

bind trap_priv_ctrl trap_priv_ctrl_chk #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_pend_i   (irq_pend_i),
    .irq_en_i     (irq_en_i),
    .trap_enter_i (trap_enter_i),
    .trap_return_i(trap_return_i),
    .priv_o       (priv_o),
    .ie_o         (ie_o),
    .pie_o        (pie_o),
    .pp_o         (pp_o),
    .mprv_o       (mprv_o),
    .irq_take_o   (irq_take_o),
    .irq_cause_o  (irq_cause_o)
);

// File: tb/trap_priv_ctrl_tb_top.sv
`timescale 1ns/1ps
module trap_priv_ctrl_tb_top;
    localparam int IRQ_W   = 16;
    localparam int CAUSE_W = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [IRQ_W-1:0]   irq_pend_i = '0, irq_en_i = '0;
    logic               trap_enter_i = 0, trap_return_i = 0, stat_wr_i = 0;
    logic               stat_ie_i = 0, stat_pie_i = 0, stat_mprv_i = 0;
    logic [1:0]         stat_pp_i = '0;
    logic [1:0]         priv_o, pp_o;
    logic               ie_o, pie_o, mprv_o, irq_take_o;
    logic [CAUSE_W-1:0] irq_cause_o;

    always #2.5 clk = ~clk;

    trap_priv_ctrl #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) dut_i (.*);

    typedef struct packed {
        logic               take;
        logic [CAUSE_W-1:0] cause;
        logic [1:0]         priv;
        logic               ie;
        logic               pie;
        logic [1:0]         pp;
        logic               mprv;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 0;

    // Bench reference state
    logic [1:0] m_priv, m_pp;
    logic       m_ie, m_pie, m_mprv;

    localparam logic [IRQ_W-1:0] SRCS = 16'h0888;

    task automatic step(input logic [IRQ_W-1:0] pend, input logic [IRQ_W-1:0] en,
                        input logic ent, input logic ret, input logic wr,
                        input logic wie, input logic wpie, input logic [1:0] wpp,
                        input logic wmprv, input string tag);
        exp_t e;
        logic [IRQ_W-1:0] r;
        logic ge;
        @(negedge clk);
        irq_pend_i = pend; irq_en_i = en;
        trap_enter_i = ent; trap_return_i = ret; stat_wr_i = wr;
        stat_ie_i = wie; stat_pie_i = wpie; stat_pp_i = wpp; stat_mprv_i = wmprv;
        r  = pend & en;
        ge = (m_priv == 2'b00) || m_ie;
        e = '0;
        if (ge && r[11])      begin e.take = 1; e.cause = 32'h8000_000B; end
        else if (ge && r[3])  begin e.take = 1; e.cause = 32'h8000_0003; end
        else if (ge && r[7])  begin e.take = 1; e.cause = 32'h8000_0007; end
        e.priv = m_priv; e.ie = m_ie; e.pie = m_pie; e.pp = m_pp; e.mprv = m_mprv;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (ent) begin
            m_pie = m_ie; m_ie = 0; m_pp = m_priv; m_priv = 2'b11;
        end else if (ret && m_priv == 2'b11) begin
            m_ie = m_pie; m_pie = 1; m_priv = m_pp;
            if (m_pp == 2'b00) m_mprv = 0;
            m_pp = 2'b00;
        end else if (wr) begin
            m_ie = wie; m_pie = wpie; m_pp = (wpp == 2'b11) ? 2'b11 : 2'b00; m_mprv = wmprv;
        end
    endtask

    task automatic idle(input string tag);
        step('0, '0, 0, 0, 0, 0, 0, 2'b00, 0, tag);
    endtask

    // Monitor: compares outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a.take = irq_take_o; a.cause = irq_cause_o; a.priv = priv_o;
                a.ie = ie_o; a.pie = pie_o; a.pp = pp_o; a.mprv = mprv_o;
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual take=%0b cause=%h priv=%b ie=%b pie=%b pp=%b mprv=%b expected take=%0b cause=%h priv=%b ie=%b pie=%b pp=%b mprv=%b",
                             t, a.take, a.cause, a.priv, a.ie, a.pie, a.pp, a.mprv,
                             e.take, e.cause, e.priv, e.ie, e.pie, e.pp, e.mprv);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        m_priv = 2'b11; m_ie = 0; m_pie = 0; m_pp = 2'b00; m_mprv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        step(SRCS, SRCS, 0, 0, 0, 0, 0, 2'b00, 0, "R2 machine mode, enable clear");
        step('0, '0, 0, 0, 1, 1, 0, 2'b11, 0, "R9 status write");
        step(SRCS, SRCS, 0, 0, 0, 0, 0, 2'b00, 0, "R5 external first");
        step(16'h0088, SRCS, 0, 0, 0, 0, 0, 2'b00, 0, "R5 software over timer");
        step(16'h0080, SRCS, 0, 0, 0, 0, 0, 2'b00, 0, "R5 timer alone");
        step(SRCS, 16'h0080, 0, 0, 0, 0, 0, 2'b00, 0, "R4 per-source enable masks");
        step(16'h0020, 16'h0020, 0, 0, 0, 0, 0, 2'b00, 0, "R4 non-source bit ignored");
        step('0, '0, 1, 0, 1, 1, 0, 2'b00, 1, "R8 entry beats status write");
        idle("R6 push after entry");
        step(16'h0800, 16'h0800, 0, 0, 0, 0, 0, 2'b00, 0, "R2 gated after entry");
        step('0, '0, 0, 0, 1, 0, 0, 2'b00, 1, "R9 write saved privilege user");
        step('0, '0, 0, 1, 1, 1, 1, 2'b11, 0, "R8 return beats status write");
        step(16'h0080, 16'h0080, 0, 0, 0, 0, 0, 2'b00, 0, "R3 user mode ignores enable bit");
        step('0, '0, 0, 1, 0, 0, 0, 2'b00, 0, "R7 return in user mode");
        idle("R7 return in user had no effect");
        step('0, '0, 0, 0, 1, 0, 0, 2'b10, 1, "R9 write in user, code 10");
        step('0, '0, 1, 1, 0, 0, 0, 2'b00, 0, "R8 entry beats return");
        idle("R6 entry from user");
        step('0, '0, 0, 0, 1, 1, 1, 2'b11, 1, "R9 write saved privilege machine");
        step('0, '0, 0, 1, 0, 0, 0, 2'b00, 0, "R7 return to machine");
        idle("R7 machine return keeps modify-privilege");
        step(16'h0008, 16'h0008, 0, 0, 0, 0, 0, 2'b00, 0, "R2 machine mode takes software");
        idle("R5 no request gives zero cause");
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule